// File: doc/BRIEF.md
# Display Panel Power-Up Sequencer

This block brings a display panel from power-on to an active picture with no processor involved. When it receives a start pulse it toggles the panel's reset pin on a fixed millisecond schedule. It then asks an external serial engine to read back an identification byte. That byte chooses one of two initialization tables held in an on-chip constant store. The block plays the chosen table one entry at a time. Each entry is a command byte followed by its parameter bytes and then a pause. It finishes with a display-enable command, a wait and a wake command, and then raises a completion flag.

The serial engine handles all bit timing. This block only presents one byte at a time over a request/acknowledge handshake and marks each byte as a command, a parameter or the identification read. The millisecond base comes from the `CLK_HZ` parameter, so a testbench can run with a very short millisecond. The parameter bytes are synthetic stand-ins produced by a fixed rule. The command codes, the parameter counts and the pauses are the real values.

Top module: `lcd_pwrup_seq`

## Requirements
- R1: While reset is held, and right after it is released, `panel_rst_n_o`, `xfer_req_o`, `done_o` and `err_o` are all low.
- R2: An accepted start drives `panel_rst_n_o` high for 100 ms, then low for 40 ms, then high for 100 ms. `xfer_req_o` stays low until the end of that last interval. One ms is CLK_HZ/1000 clock cycles.
- R3: The first transfer after the reset pulse is the ID read: `xfer_rd_o`=1, `xfer_dc_o`=0, `xfer_byte_o`=0x04. The byte returned on `xfer_id_i` is taken in the cycle of `xfer_ack_i`.
- R4: An ID of 0x80 selects table A, whose 8 command codes are 36,3A,B6,C5,E0,E1,B0,B4. Any other ID selects table B, whose 22 codes are FF,BA,BC,BD,BE,C7,ED,C0,FC,B6,DF,F3,B4,F7,B1,F2,C1,36,3A,E0,E1,35. Codes are in hex and are sent in that order.
- R5: Each entry sends its code with `xfer_dc_o`=0, then its parameters with `xfer_dc_o`=1, and the next byte follows in the cycle after an ack. Parameter counts for A are 1,1,4,2,16,16,1,1. For B they are 3,1,21,8,9,1,3,3,1,1,6,1,3,1,3,4,4,1,1,16,16,1. Parameter k (counted from 0) of code C is 0x66 when C=3A, is FF,98,06 for k=0,1,2 when C=FF, and is (C+k+1) mod 256 for every other code.
- R6: After the last byte of an entry, the request stays low for d·CLK_HZ/1000 cycles, where d is the entry's pause, or for exactly one cycle when d=0. In table A the sixth entry (E1) has d=20 and the eighth (B4) has d=100. Every other entry has d=0.
- R7: After the table, code 0x29 is sent with no parameters. The request then stays low for 100 ms, code 0x11 is sent with no parameters, and `done_o` rises in the cycle after that transfer's ack.
- R8: `done_o` stays high, with no requests, until the next accepted start. The start edge clears it.
- R9: An ack that comes with `xfer_err_i` high sets `err_o`. The sequence still runs to the end, and `err_o` stays set until the next accepted start clears it.
- R10: A start pulse is ignored while a sequence is running. Neither the pin timing nor the transfer stream changes.
- R11: Once raised, `xfer_req_o` and its byte, rd and dc qualifiers hold steady until an ack arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside |
| start_i | input | 1 | Begin a power-up sequence (accepted when idle or done) |
| panel_rst_n_o | output | 1 | Panel reset pin |
| xfer_req_o | output | 1 | Transfer request to the serial engine |
| xfer_rd_o | output | 1 | Request is the ID read |
| xfer_dc_o | output | 1 | 0 = command byte, 1 = parameter byte |
| xfer_byte_o | output | 8 | Byte to send |
| xfer_ack_i | input | 1 | Engine has completed the current transfer |
| xfer_err_i | input | 1 | Transfer failed, qualified by ack |
| xfer_id_i | input | 8 | ID byte returned by the read, qualified by ack |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | Sticky transfer-error flag |

## Verification
The hardest cases to reach from the ports are a start arriving in the middle of the reset pulse or in the middle of the table, and an error reported on a transfer deep inside the stream. The bench models the serial engine with an adjustable acknowledge latency. It fires stray start pulses at set points in the low phase and during table playback. It injects an error on a chosen transfer index. It then compares the whole logged stream, including the idle gaps between transfers, against a sequence rebuilt from the requirement tables, for a spread of ID values on both sides of 0x80.

// File: rtl/lcd_pwrup_pkg.sv
package lcd_pwrup_pkg;
  localparam int CNT_W = 5;
  localparam int MS_W  = 8;
  localparam int TBL_A_LEN = 8;
  localparam int TBL_B_LEN = 22;

  localparam logic [7:0] ID_CMD      = 8'h04;
  localparam logic [7:0] ID_MATCH    = 8'h80;
  localparam logic [7:0] CMD_DISP_ON = 8'h29;
  localparam logic [7:0] CMD_WAKE    = 8'h11;

  localparam logic [MS_W-1:0] RST_HI_MS  = MS_W'(100);
  localparam logic [MS_W-1:0] RST_LO_MS  = MS_W'(40);
  localparam logic [MS_W-1:0] ON_WAIT_MS = MS_W'(100);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RHI, ST_RLO, ST_RSET, ST_ID, ST_CMD,
    ST_PAR, ST_GAP, ST_ON, ST_ONW, ST_WAKE, ST_DONE
  } seq_st_t;

  typedef struct packed {
    logic [7:0]      code;
    logic [CNT_W-1:0] npar;
    logic [MS_W-1:0]  ms;
  } ent_t;
endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int CLK_HZ = 50_000_000,
  parameter int MS_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            fin_o
);
  localparam int PER = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int PW  = (PER > 1) ? $clog2(PER) : 1;
  localparam logic [PW-1:0] PER_M1 = PW'(PER - 1);

  logic [MS_W-1:0] ms_q, ms_d;
  logic [PW-1:0]   pre_q, pre_d;
  logic            wrap;

  assign wrap  = (pre_q == PER_M1);
  // look one cycle ahead so a wait of d ms lasts exactly d*PER cycles
  assign fin_o = (ms_q == '0) || ((ms_q == MS_W'(1)) && wrap);

  always_comb begin
    ms_d  = ms_q;
    pre_d = pre_q;
    if (load_i) begin
      ms_d  = ms_i;
      pre_d = '0;
    end else if (ms_q != '0) begin
      if (wrap) begin
        pre_d = '0;
        ms_d  = ms_q - MS_W'(1);
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      pre_q <= '0;
    end else begin
      ms_q  <= ms_d;
      pre_q <= pre_d;
    end
  end

  AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && ms_q != '0) |=> (ms_q <= $past(ms_q))); // R6
endmodule

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
  import lcd_pwrup_pkg::*;
(
  input  logic             sel_b_i,
  input  logic [CNT_W-1:0] ent_i,
  input  logic [CNT_W-1:0] par_i,
  output ent_t             ent_o,
  output logic [7:0]       pbyte_o,
  output logic             last_o
);
  function automatic ent_t mk(input logic [7:0] c, input int n, input int ms);
    ent_t e;
    e.code = c;
    e.npar = CNT_W'(n);
    e.ms   = MS_W'(ms);
    return e;
  endfunction

  always_comb begin
    ent_o = mk(8'h00, 0, 0);
    if (!sel_b_i) begin
      case (ent_i)
        5'd0:    ent_o = mk(8'h36, 1, 0);
        5'd1:    ent_o = mk(8'h3A, 1, 0);
        5'd2:    ent_o = mk(8'hB6, 4, 0);
        5'd3:    ent_o = mk(8'hC5, 2, 0);
        5'd4:    ent_o = mk(8'hE0, 16, 0);
        5'd5:    ent_o = mk(8'hE1, 16, 20);
        5'd6:    ent_o = mk(8'hB0, 1, 0);
        5'd7:    ent_o = mk(8'hB4, 1, 100);
        default: ent_o = mk(8'h00, 0, 0);
      endcase
    end else begin
      case (ent_i)
        5'd0:    ent_o = mk(8'hFF, 3, 0);
        5'd1:    ent_o = mk(8'hBA, 1, 0);
        5'd2:    ent_o = mk(8'hBC, 21, 0);
        5'd3:    ent_o = mk(8'hBD, 8, 0);
        5'd4:    ent_o = mk(8'hBE, 9, 0);
        5'd5:    ent_o = mk(8'hC7, 1, 0);
        5'd6:    ent_o = mk(8'hED, 3, 0);
        5'd7:    ent_o = mk(8'hC0, 3, 0);
        5'd8:    ent_o = mk(8'hFC, 1, 0);
        5'd9:    ent_o = mk(8'hB6, 1, 0);
        5'd10:   ent_o = mk(8'hDF, 6, 0);
        5'd11:   ent_o = mk(8'hF3, 1, 0);
        5'd12:   ent_o = mk(8'hB4, 3, 0);
        5'd13:   ent_o = mk(8'hF7, 1, 0);
        5'd14:   ent_o = mk(8'hB1, 3, 0);
        5'd15:   ent_o = mk(8'hF2, 4, 0);
        5'd16:   ent_o = mk(8'hC1, 4, 0);
        5'd17:   ent_o = mk(8'h36, 1, 0);
        5'd18:   ent_o = mk(8'h3A, 1, 0);
        5'd19:   ent_o = mk(8'hE0, 16, 0);
        5'd20:   ent_o = mk(8'hE1, 16, 0);
        5'd21:   ent_o = mk(8'h35, 1, 0);
        default: ent_o = mk(8'h00, 0, 0);
      endcase
    end
  end

  always_comb begin
    if (ent_o.code == 8'h3A) begin
      pbyte_o = 8'h66;
    end else if (ent_o.code == 8'hFF) begin
      case (par_i)
        5'd0:    pbyte_o = 8'hFF;
        5'd1:    pbyte_o = 8'h98;
        default: pbyte_o = 8'h06;
      endcase
    end else begin
      pbyte_o = ent_o.code + 8'(par_i) + 8'd1;
    end
  end

  assign last_o = (ent_i == (sel_b_i ? CNT_W'(TBL_B_LEN - 1) : CNT_W'(TBL_A_LEN - 1)));
endmodule

// File: rtl/lcd_pwrup_seq.sv
module lcd_pwrup_seq
  import lcd_pwrup_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       panel_rst_n_o,
  output logic       xfer_req_o,
  output logic       xfer_rd_o,
  output logic       xfer_dc_o,
  output logic [7:0] xfer_byte_o,
  input  logic       xfer_ack_i,
  input  logic       xfer_err_i,
  input  logic [7:0] xfer_id_i,
  output logic       done_o,
  output logic       err_o
);
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] ent_q, ent_d, par_q, par_d;
  logic             tbl_q, tbl_d, ran_q, ran_d, err_q, err_d;
  logic             tmr_load, tmr_fin;
  logic [MS_W-1:0]  tmr_ms;
  ent_t             rom_e;
  logic [7:0]       rom_pb;
  logic             rom_last, start_ok;

  lcd_init_rom u_rom (
    .sel_b_i (tbl_q),
    .ent_i   (ent_q),
    .par_i   (par_q),
    .ent_o   (rom_e),
    .pbyte_o (rom_pb),
    .last_o  (rom_last)
  );

  lcd_ms_timer #(.CLK_HZ(CLK_HZ), .MS_W(MS_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (tmr_load),
    .ms_i   (tmr_ms),
    .fin_o  (tmr_fin)
  );

  always_comb begin
    xfer_req_o  = 1'b0;
    xfer_rd_o   = 1'b0;
    xfer_dc_o   = 1'b0;
    xfer_byte_o = 8'h00;
    case (st_q)
      ST_ID:   begin xfer_req_o = 1'b1; xfer_rd_o = 1'b1; xfer_byte_o = ID_CMD; end
      ST_CMD:  begin xfer_req_o = 1'b1; xfer_byte_o = rom_e.code; end
      ST_PAR:  begin xfer_req_o = 1'b1; xfer_dc_o = 1'b1; xfer_byte_o = rom_pb; end
      ST_ON:   begin xfer_req_o = 1'b1; xfer_byte_o = CMD_DISP_ON; end
      ST_WAKE: begin xfer_req_o = 1'b1; xfer_byte_o = CMD_WAKE; end
      default: ;
    endcase
  end

  assign start_ok = start_i && (st_q == ST_IDLE || st_q == ST_DONE);

  always_comb begin
    st_d     = st_q;
    ent_d    = ent_q;
    par_d    = par_q;
    tbl_d    = tbl_q;
    ran_d    = ran_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    tmr_ms   = '0;
    case (st_q)
      ST_IDLE, ST_DONE: if (start_ok) begin
        st_d = ST_RHI; ran_d = 1'b1; err_d = 1'b0;
        tmr_load = 1'b1; tmr_ms = RST_HI_MS;
      end
      ST_RHI: if (tmr_fin) begin
        st_d = ST_RLO; tmr_load = 1'b1; tmr_ms = RST_LO_MS;
      end
      ST_RLO: if (tmr_fin) begin
        st_d = ST_RSET; tmr_load = 1'b1; tmr_ms = RST_HI_MS;
      end
      ST_RSET: if (tmr_fin) st_d = ST_ID;
      ST_ID: if (xfer_ack_i) begin
        tbl_d = (xfer_id_i != ID_MATCH);
        ent_d = '0;
        par_d = '0;
        st_d  = ST_CMD;
      end
      ST_CMD: if (xfer_ack_i) begin
        par_d = '0;
        if (rom_e.npar != '0) begin
          st_d = ST_PAR;
        end else begin
          st_d = ST_GAP; tmr_load = 1'b1; tmr_ms = rom_e.ms;
        end
      end
      ST_PAR: if (xfer_ack_i) begin
        if (par_q == rom_e.npar - CNT_W'(1)) begin
          st_d = ST_GAP; tmr_load = 1'b1; tmr_ms = rom_e.ms;
        end else begin
          par_d = par_q + CNT_W'(1);
        end
      end
      ST_GAP: if (tmr_fin) begin
        if (rom_last) begin
          st_d = ST_ON;
        end else begin
          ent_d = ent_q + CNT_W'(1);
          st_d  = ST_CMD;
        end
      end
      ST_ON: if (xfer_ack_i) begin
        st_d = ST_ONW; tmr_load = 1'b1; tmr_ms = ON_WAIT_MS;
      end
      ST_ONW:  if (tmr_fin) st_d = ST_WAKE;
      ST_WAKE: if (xfer_ack_i) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
    if (xfer_req_o && xfer_ack_i && xfer_err_i) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q  <= ST_IDLE;
      ent_q <= '0;
      par_q <= '0;
      tbl_q <= 1'b0;
      ran_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ent_q <= ent_d;
      par_q <= par_d;
      tbl_q <= tbl_d;
      ran_q <= ran_d;
      err_q <= err_d;
    end
  end

  assign panel_rst_n_o = ran_q && (st_q != ST_RLO);
  assign done_o        = (st_q == ST_DONE);
  assign err_o         = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_byte_o) && $stable(xfer_dc_o) && $stable(xfer_rd_o))); // R11
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !panel_rst_n_o |-> !xfer_req_o); // R2
  AST_ID_FORM: assert property (@(posedge clk) disable iff (!rst_n_s)
    xfer_rd_o |-> (xfer_req_o && !xfer_dc_o && xfer_byte_o == ID_CMD)); // R3
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && !start_i) |=> done_o); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (err_o && !start_i) |=> err_o); // R9
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n_s)
    (xfer_req_o && start_i) |=> panel_rst_n_o); // R10
endmodule

// File: tb/lcd_pwrup_seq_test.sv
module lcd_pwrup_seq_test;
  localparam int CLK_HZ = 4000;
  localparam int P      = CLK_HZ / 1000;
  localparam int WD     = 190000;

  localparam int A_CODE [8] = '{'h36, 'h3A, 'hB6, 'hC5, 'hE0, 'hE1, 'hB0, 'hB4};
  localparam int A_NP   [8] = '{1, 1, 4, 2, 16, 16, 1, 1};
  localparam int A_MS   [8] = '{0, 0, 0, 0, 0, 20, 0, 100};
  localparam int B_CODE [22] = '{'hFF, 'hBA, 'hBC, 'hBD, 'hBE, 'hC7, 'hED, 'hC0, 'hFC, 'hB6, 'hDF,
                                 'hF3, 'hB4, 'hF7, 'hB1, 'hF2, 'hC1, 'h36, 'h3A, 'hE0, 'hE1, 'h35};
  localparam int B_NP   [22] = '{3, 1, 21, 8, 9, 1, 3, 3, 1, 1, 6, 1, 3, 1, 3, 4, 4, 1, 1, 16, 16, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ack = 1'b0;
  logic xerr = 1'b0;
  logic [7:0] idv = 8'h00;
  logic pin, req, rd, dc, done, err;
  logic [7:0] byt;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int lat = 1;
  int err_at = -1;
  int n_log = 0;
  int wait_n = 0;
  int gap = 0;
  int hold_bad = 0;
  logic [7:0] held;
  int lg_byte [256];
  int lg_dc   [256];
  int lg_rd   [256];
  int lg_gap  [256];
  int eb [256];
  int ed [256];
  int er [256];
  int eg [256];
  int n_exp;

  always #2 clk = ~clk;

  lcd_pwrup_seq #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .panel_rst_n_o(pin),
    .xfer_req_o(req), .xfer_rd_o(rd), .xfer_dc_o(dc), .xfer_byte_o(byt),
    .xfer_ack_i(ack), .xfer_err_i(xerr), .xfer_id_i(idv),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // serial engine model, acting between clock edges
  always @(negedge clk) begin
    if (ack) begin
      ack = 1'b0;
      xerr = 1'b0;
      wait_n = 0;
    end
    if (req) begin
      if (wait_n == 0) held = byt;
      else if (byt != held) hold_bad++;
      if (wait_n == lat) begin
        if (n_log < 256) begin
          lg_byte[n_log] = int'(byt);
          lg_dc[n_log]   = int'(dc);
          lg_rd[n_log]   = int'(rd);
          lg_gap[n_log]  = gap;
        end
        xerr = (n_log == err_at);
        n_log++;
        gap = 0;
        ack = 1'b1;
      end else begin
        wait_n++;
      end
    end else begin
      gap++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WD);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int pgen(input int c, input int k);
    if (c == 'h3A) return 'h66;
    if (c == 'hFF) return (k == 0) ? 'hFF : (k == 1) ? 'h98 : 'h06;
    return (c + k + 1) % 256;
  endfunction

  function automatic int gapof(input int d);
    return (d == 0) ? 1 : d * P;
  endfunction

  task automatic build(input bit use_b);
    int n = 0;
    int prev_gap = 0;
    int len = use_b ? 22 : 8;
    eb[n] = 'h04; ed[n] = 0; er[n] = 1; eg[n] = -1; n++;
    for (int e = 0; e < len; e++) begin
      int c  = use_b ? B_CODE[e] : A_CODE[e];
      int np = use_b ? B_NP[e] : A_NP[e];
      int ms = use_b ? 0 : A_MS[e];
      eb[n] = c; ed[n] = 0; er[n] = 0; eg[n] = prev_gap; n++;
      for (int k = 0; k < np; k++) begin
        eb[n] = pgen(c, k); ed[n] = 1; er[n] = 0; eg[n] = 0; n++;
      end
      prev_gap = gapof(ms);
    end
    eb[n] = 'h29; ed[n] = 0; er[n] = 0; eg[n] = prev_gap; n++;
    eb[n] = 'h11; ed[n] = 0; er[n] = 0; eg[n] = 100 * P; n++;
    n_exp = n;
  endtask

  task automatic run(input logic [7:0] id, input int lat_v, input int err_idx, input bit poke);
    int n;
    bit fell = 0;
    bit use_b = (id != 8'h80);
    build(use_b);
    idv = id; lat = lat_v; err_at = err_idx; n_log = 0; hold_bad = 0; gap = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R8", "done cleared by start", done, 0);
    chk(err == 1'b0, "R9", "error cleared by start", err, 0);
    n = 0;
    while (pin && n < 2000) begin n++; @(negedge clk); end
    chk(n == 100 * P, "R2", "first high phase", n, 100 * P);
    n = 0;
    while (!pin && n < 2000) begin
      start = (poke && n == 3);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == 40 * P, "R2", "low phase (R10 stray start)", n, 40 * P);
    n = 0;
    while (!req && n < 2000) begin n++; @(negedge clk); end
    chk(n == 100 * P, "R2", "second high phase before request", n, 100 * P);
    n = 0;
    while (!done && n < 20000) begin
      if (!pin) fell = 1;
      start = (poke && n == 200);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R7", "done after wake command", done, 1);
    chk(!fell, "R10", "pin stayed high during playback", fell, 0);
    chk(n_log == n_exp, use_b ? "R4" : "R4", "transfer count", n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      if (i == 0) begin
        chk(lg_byte[i] == 'h04 && lg_rd[i] == 1 && lg_dc[i] == 0, "R3", "ID read form", lg_byte[i], 'h04);
      end else begin
        chk(lg_byte[i] == eb[i], ed[i] ? "R5" : "R4", $sformatf("byte #%0d", i), lg_byte[i], eb[i]);
        chk(lg_dc[i] == ed[i] && lg_rd[i] == 0, "R5", $sformatf("dc #%0d", i), lg_dc[i], ed[i]);
        chk(lg_gap[i] == eg[i], (i >= n_exp - 2) ? "R7" : "R6", $sformatf("gap #%0d", i), lg_gap[i], eg[i]);
      end
    end
    chk(err == (err_idx >= 0), "R9", "sticky error after run", err, (err_idx >= 0));
    chk(hold_bad == 0, "R11", "byte held until ack", hold_bad, 0);
    n = 0;
    repeat (30) begin
      @(negedge clk);
      if (!done || req) n++;
    end
    chk(n == 0, "R8", "done held with no requests", n, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(pin == 0 && req == 0, "R1", "pin/req in reset", {pin, req}, 0);
    chk(done == 0 && err == 0, "R1", "done/err in reset", {done, err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pin == 0 && req == 0 && done == 0 && err == 0, "R1", "idle after reset", {pin, req, done, err}, 0);

    run(8'h80, 1, -1, 1'b0);
    run(8'h00, 2, 5, 1'b1);
    run(8'h80, 0, 40, 1'b1);
    run(8'h7F, 1, -1, 1'b0);
    run(8'h81, 0, -1, 1'b1);
    run(8'hFF, 3, 130, 1'b0);
    run(8'h08, 2, -1, 1'b0);
    run(8'h80, 3, -1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule